// File: doc/BRIEF.md
# Core Module System Control Register Bank

This block is the small register bank that a processor core module exposes on its local register bus. It answers with a fixed identification word and a fixed status word. It holds two clock-oscillator settings that software may change only after it has written an unlock key. A control register drives a board LED and selects whether the boot flash overlays address zero, and it can raise a system reset request. The bank also provides two set/clear flag registers, two plain read/write configuration words and a read-only window onto the presence-detect bytes of the fitted SDRAM module.

The bus is word addressed and has separate read and write strobes. A write takes effect on the clock edge where `wr_en` is high. A read is captured on the clock edge where `rd_en` is high, and `rd_data` then holds that word until the next read. The installed memory size is the parameter `MEM_MB`, given in megabytes. The size code in the SDRAM register is derived from it when the design is elaborated.

Top module: `cm_sysctrl_regs`

## Requirements
- R1: A read of word 0 returns 0x411A3001, a read of word 4 returns 0x00100000 and a read of word 1 returns 0. Writes do not change any of these words.
- R2: After reset, the following hold. Word 2 (oscillator) reads 0x01000048, word 7 (auxiliary oscillator) reads 0x0007FEFF and word 9 (init) reads 0x00000112. Word 8 (SDRAM) reads 0x00011122 ORed with the size code: 0x10 when MEM_MB is 256 or more, 0x0C for 128 to 255, 0x08 for 64 to 127, 0x04 for 32 to 63, and 0 below 32. With the default MEM_MB of 128, word 8 reads 0x0001112E. Words 3, 5, 12 and 14 read 0, `rd_data` is 0, `boot_overlay_en` is 1, `led_on` is 0 and `sys_reset_req` is 0.
- R3: A write to word 5 (lock) stores bits 15:0 of the written value only. A read of word 5 returns 0x0001A05F when the stored value is 0xA05F, and returns the stored value zero-extended otherwise.
- R4: A write to word 2 or word 7 changes that register only when the lock register holds 0xA05F at the time of the write. Otherwise the register keeps its old value.
- R5: A write to word 3 with bit 3 set drives `sys_reset_req` high for exactly the one cycle after that write. `sys_reset_req` is low in every other cycle.
- R6: Word 3 stores bit 0 (LED) and bit 2 (remap) of a write, and reads back as {29'b0, remap, 1'b0, LED}, so bits 1 and 3 always read 0. `led_on` equals the stored LED bit, and `boot_overlay_en` is the inverse of the stored remap bit. Both outputs change in the cycle after the write.
- R7: A write to word 12 ORs the written value into the flags register. A write to word 13 clears the flags bits that are 1 in the written value. A read of word 12 returns the flags register, and a read of word 13 returns 0.
- R8: Words 14 and 15 set and clear the non-volatile flags register in the same way as R7. A read of word 14 returns that register, and a read of word 15 returns 0.
- R9: A read of a word in the range 0x40 to 0x5F returns, zero-extended, byte N of the presence-detect table, where N is the word address. Bytes 73 to 83 hold the ASCII text "CM-SDRAM-01" in order, and every other byte is 0. Words 0x60 to 0x7F read 0. Writes to words 0x40 to 0x7F change nothing.
- R10: Words 8 and 9 store all 32 bits of a write and read them back.
- R11: A read of any word not named in R1 to R10, such as 6, 10, 11, 16 or 0x3F, returns 0, and writes to those words change no register.
- R12: `rd_data` takes the addressed word on the clock edge where `rd_en` is high and keeps it until the next read. A read and a write in the same cycle return the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| boot_overlay_en | output | 1 | Boot flash overlays address zero while high |
| led_on | output | 1 | LED drive |

## Verification
Oscillator writes are tried in three lock states: no key, a wrong key whose upper bits are set, and the correct key. The cases are then repeated after the lock is dropped again. This separates a gate on the full 32-bit value from a gate on the low half, and a gate that stays latched from one that tracks the lock. Control writes use the values 0xF, 0x4, 0x8 and 0. These tell apart the stored bits, the bits that always read 0, the inverted overlay sense and a reset pulse that lasts one cycle or sticks. Overlapping set and clear masks on both flag registers, a sweep of the whole presence-detect window, and a read issued in the same cycle as a write complete the patterns.

// File: rtl/cm_sysctrl_regs.sv
module cm_sysctrl_regs #(
  parameter int MEM_MB = 128,
  parameter int AW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          sys_reset_req,
  output logic          boot_overlay_en,
  output logic          led_on
);

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SIZE_CODE  = (MEM_MB >= 256) ? 32'h10 :
                                       (MEM_MB >= 128) ? 32'h0C :
                                       (MEM_MB >= 64)  ? 32'h08 :
                                       (MEM_MB >= 32)  ? 32'h04 : 32'h00;
  localparam logic [31:0] SDRAM_RST  = 32'h0001_1122 | SIZE_CODE;

  localparam logic [AW-1:0] W_ID     = AW'(0);
  localparam logic [AW-1:0] W_OSC    = AW'(2);
  localparam logic [AW-1:0] W_CTRL   = AW'(3);
  localparam logic [AW-1:0] W_STAT   = AW'(4);
  localparam logic [AW-1:0] W_LOCK   = AW'(5);
  localparam logic [AW-1:0] W_AUX    = AW'(7);
  localparam logic [AW-1:0] W_SDRAM  = AW'(8);
  localparam logic [AW-1:0] W_INIT   = AW'(9);
  localparam logic [AW-1:0] W_FSET   = AW'(12);
  localparam logic [AW-1:0] W_FCLR   = AW'(13);
  localparam logic [AW-1:0] W_NVSET  = AW'(14);
  localparam logic [AW-1:0] W_NVCLR  = AW'(15);
  localparam logic [AW-1:0] W_PD_LO  = AW'(64);
  localparam logic [AW-1:0] W_PD_HI  = AW'(95);

  localparam int          PD_NAME_AT  = 73;
  localparam int          PD_NAME_LEN = 11;
  localparam logic [8*PD_NAME_LEN-1:0] PD_NAME = "CM-SDRAM-01";

  logic [31:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [15:0] lock_q;
  logic        led_q, remap_q, req_q;
  logic [31:0] rd_mux;
  logic        unlocked;

  function automatic logic [7:0] pd_byte(input int unsigned idx);
    if (idx >= PD_NAME_AT && idx < PD_NAME_AT + PD_NAME_LEN)
      return PD_NAME[8*(PD_NAME_AT + PD_NAME_LEN - 1 - idx) +: 8];
    return 8'h00;
  endfunction

  assign unlocked        = (lock_q == UNLOCK_KEY);
  assign sys_reset_req   = req_q;
  assign boot_overlay_en = ~remap_q;
  assign led_on          = led_q;

  always_comb begin
    rd_mux = '0;
    if (addr >= W_PD_LO && addr <= W_PD_HI) begin
      rd_mux = {24'b0, pd_byte(32'(addr))};
    end else begin
      case (addr)
        W_ID:    rd_mux = ID_WORD;
        W_OSC:   rd_mux = osc_q;
        W_CTRL:  rd_mux = {29'b0, remap_q, 1'b0, led_q};
        W_STAT:  rd_mux = STAT_WORD;
        W_LOCK:  rd_mux = {15'b0, unlocked, lock_q};
        W_AUX:   rd_mux = aux_q;
        W_SDRAM: rd_mux = sdram_q;
        W_INIT:  rd_mux = init_q;
        W_FSET:  rd_mux = flags_q;
        W_NVSET: rd_mux = nvflags_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      flags_q   <= '0;
      nvflags_q <= '0;
      lock_q    <= '0;
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      req_q     <= 1'b0;
      rd_data   <= '0;
    end else begin
      req_q <= wr_en && (addr == W_CTRL) && wr_data[3];
      if (rd_en) rd_data <= rd_mux;
      if (wr_en) begin
        case (addr)
          W_OSC:   if (unlocked) osc_q <= wr_data;
          W_AUX:   if (unlocked) aux_q <= wr_data;
          W_CTRL:  begin
                     led_q   <= wr_data[0];
                     remap_q <= wr_data[2];
                   end
          W_LOCK:  lock_q    <= wr_data[15:0];
          W_SDRAM: sdram_q   <= wr_data;
          W_INIT:  init_q    <= wr_data;
          W_FSET:  flags_q   <= flags_q | wr_data;
          W_FCLR:  flags_q   <= flags_q & ~wr_data;
          W_NVSET: nvflags_q <= nvflags_q | wr_data;
          W_NVCLR: nvflags_q <= nvflags_q & ~wr_data;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cm_sysctrl_regs_chk.sv
module cm_sysctrl_regs_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          sys_reset_req,
  input logic          boot_overlay_en,
  input logic          led_on,
  input logic [31:0]   osc_q,
  input logic [31:0]   aux_q,
  input logic [15:0]   lock_q,
  input logic [31:0]   flags_q
);

  // R5
  reset_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_en && addr == AW'(3) && wr_data[3]));

  // R5
  reset_pulse_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3) && wr_data[3]) |=> sys_reset_req);

  // R6
  overlay_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> (boot_overlay_en == !$past(wr_data[2]) && led_on == $past(wr_data[0])));

  // R4
  osc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2) && lock_q != 16'hA05F) |=> $stable(osc_q));

  // R4
  aux_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(7) && lock_q != 16'hA05F) |=> $stable(aux_q));

  // R3
  lock_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(5)) |=> lock_q == $past(wr_data[15:0]));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12)) |=> (flags_q & $past(wr_data)) == $past(wr_data));

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(13)) |=> (flags_q & $past(wr_data)) == 32'h0);

endmodule

bind cm_sysctrl_regs cm_sysctrl_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .sys_reset_req(sys_reset_req), .boot_overlay_en(boot_overlay_en), .led_on(led_on),
  .osc_q(osc_q), .aux_q(aux_q), .lock_q(lock_q), .flags_q(flags_q)
);

// File: tb/cm_sysctrl_regs_tb.sv
`timescale 1ns/1ps
module cm_sysctrl_regs_tb;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic          sys_reset_req, boot_overlay_en, led_on;

  int n_checks = 0;
  int n_fail   = 0;
  bit chk_on   = 1'b0;
  bit done     = 1'b0;
  string tag   = "R2";

  // reference model state
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_rd;
  logic [15:0] m_lock;
  bit          m_led, m_remap, m_req;

  always #2 clk = ~clk;

  cm_sysctrl_regs #(.MEM_MB(128), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sys_reset_req(sys_reset_req),
    .boot_overlay_en(boot_overlay_en), .led_on(led_on)
  );

  task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    string nm = "CM-SDRAM-01";
    if (a >= 64 && a <= 95) begin
      if (a >= 73 && a <= 83) return {24'b0, nm[a-73]};
      return 0;
    end
    case (a)
      0:  return 32'h411A3001;
      4:  return 32'h00100000;
      2:  return m_osc;
      3:  return {29'b0, m_remap, 1'b0, m_led};
      5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'b0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      12: return m_flags;
      14: return m_nv;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    case (a)
      2:  if (m_lock == 16'hA05F) m_osc = d;
      7:  if (m_lock == 16'hA05F) m_aux = d;
      3:  begin m_led = d[0]; m_remap = d[2]; end
      5:  m_lock = d[15:0];
      8:  m_sdram = d;
      9:  m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      default: ;
    endcase
  endtask

  task automatic cyc(input string t, input bit we, input bit re, input int a, input logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    tag = t;
    wr_en = we; rd_en = re; addr = AW'(a); wr_data = d;
    @(posedge clk);
    e = re ? m_read(a) : m_rd;
    if (we) m_write(a, d);
    m_req = we && (a == 3) && d[3];
    m_rd = e;
    #0.5;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input string t, input int a, input logic [31:0] d);
    cyc(t, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input string t, input int a);
    cyc(t, 1'b0, 1'b1, a, 32'h0);
  endtask

  // compare outputs against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (chk_on) begin
      check(tag, "rd_data", rd_data, m_rd);
      check("R5", "sys_reset_req", {31'b0, sys_reset_req}, {31'b0, m_req});
      check("R6", "boot_overlay_en", {31'b0, boot_overlay_en}, {31'b0, !m_remap});
      check("R6", "led_on", {31'b0, led_on}, {31'b0, m_led});
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_init = 32'h00000112;
    m_sdram = 32'h0001112E; m_flags = 0; m_nv = 0; m_lock = 0;
    m_led = 0; m_remap = 0; m_req = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R2 reset values
    rd("R2", 2); rd("R2", 7); rd("R2", 9); rd("R2", 8);
    rd("R2", 3); rd("R2", 5); rd("R2", 12); rd("R2", 14);
    check("R2", "sdram reset literal", m_rd, 32'h0);
    rd("R2", 8);
    check("R2", "sdram size code", rd_data, 32'h0001112E);

    // R1 constants, unaffected by writes
    rd("R1", 0); rd("R1", 4); rd("R1", 1);
    wr("R1", 0, 32'hFFFFFFFF); wr("R1", 4, 32'h0); wr("R1", 1, 32'h5);
    rd("R1", 0); rd("R1", 4); rd("R1", 1);

    // R4 locked writes ignored, R3 wrong key with high bits
    wr("R4", 2, 32'hDEADBEEF); wr("R4", 7, 32'h12345678);
    rd("R4", 2); rd("R4", 7);
    wr("R3", 5, 32'hFFFF1234); rd("R3", 5);
    wr("R4", 2, 32'hDEADBEEF); rd("R4", 2);
    wr("R3", 5, 32'h0000A05F); rd("R3", 5);
    check("R3", "lock key readback", rd_data, 32'h0001A05F);
    wr("R3", 5, 32'h7777A05F); rd("R3", 5);
    wr("R4", 2, 32'hCAFEF00D); wr("R4", 7, 32'h00ABCDEF);
    rd("R4", 2); rd("R4", 7);
    check("R4", "osc unlocked write", m_osc, 32'hCAFEF00D);
    wr("R3", 5, 32'h0); rd("R3", 5);
    wr("R4", 2, 32'h11111111); wr("R4", 7, 32'h22222222);
    rd("R4", 2); rd("R4", 7);

    // R5 R6 control
    wr("R5", 3, 32'h0000000F); rd("R6", 3);
    check("R6", "ctrl readback", rd_data, 32'h5);
    wr("R6", 3, 32'h00000004); rd("R6", 3);
    wr("R5", 3, 32'h00000008); rd("R6", 3);
    wr("R5", 3, 32'h00000008); wr("R5", 3, 32'h00000008);
    wr("R6", 3, 32'h0); rd("R6", 3);
    wr("R6", 3, 32'hFFFFFFF3); rd("R6", 3);
    wr("R6", 3, 32'h0);

    // R7 flags, R8 non-volatile flags
    wr("R7", 12, 32'h0000F0F0); wr("R7", 12, 32'h0F000001); rd("R7", 12);
    wr("R7", 13, 32'h000030F1); rd("R7", 12); rd("R7", 13);
    wr("R8", 14, 32'hA5A5A5A5); wr("R8", 15, 32'hFF00FF00); rd("R8", 14);
    wr("R8", 14, 32'h00010000); rd("R8", 14); rd("R8", 15);
    rd("R7", 12);

    // R10 full-width read/write words
    wr("R10", 8, 32'h89ABCDEF); wr("R10", 9, 32'h76543210);
    rd("R10", 8); rd("R10", 9);

    // R9 presence-detect window sweep and writes ignored
    for (int a = 64; a < 128; a++) wr("R9", a, 32'hFFFFFFFF);
    for (int a = 64; a < 128; a++) rd("R9", a);
    rd("R9", 73);
    check("R9", "first name char", rd_data, 32'h43);

    // R11 unimplemented words
    wr("R11", 6, 32'hFFFFFFFF); wr("R11", 10, 32'h1); wr("R11", 11, 32'h2);
    wr("R11", 16, 32'h3); wr("R11", 63, 32'h4);
    rd("R11", 6); rd("R11", 10); rd("R11", 11); rd("R11", 16); rd("R11", 63);
    rd("R11", 8); rd("R11", 9); rd("R11", 12); rd("R11", 14);

    // R12 read in same cycle as write returns old value; data holds
    cyc("R12", 1'b1, 1'b1, 9, 32'h0BADC0DE);
    check("R12", "old value on rd+wr", rd_data, 32'h76543210);
    cyc("R12", 1'b0, 1'b0, 0, 32'h0);
    cyc("R12", 1'b1, 1'b0, 8, 32'h0);
    rd("R12", 9);
    cyc("R12", 1'b1, 1'b1, 12, 32'h80000000);
    rd("R12", 12);

    repeat (2) @(negedge clk);
    chk_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule